// File: doc/BRIEF.md
# Sampled Phase-Frequency Comparator with Digital Charge Integrator

This block compares two clock-like inputs, a reference and a feedback signal, using only a fast system clock. Both inputs are sampled, and a rising edge is taken as a sample that is high where the previous sample was low. A three-state machine turns the order of these edges into two pump outputs. `up` means the reference is ahead and `dn` means the feedback is ahead. Each pump pulse lasts as many system clocks as separate the two edges.

A signed saturating accumulator stands in for the analogue charge pump and loop-filter capacitor. While `up` alone is high it rises by a fixed step each clock, while `dn` alone is high it falls by the same step, and otherwise it holds. A lock monitor watches how wide the pulses are. It raises `locked` once enough reference periods in a row have carried no pulse wider than a programmable limit.

Top module: `pfd_integrator`

## Requirements
- R1: A synchronous active-high `rst` forces `up`, `dn`, `acc` and `locked` to 0 on the next clock edge, whatever the inputs and the state.
- R2: When both pump outputs are low, a rising edge on `ref_in` raises `up`. `up` is high on the second system clock edge after the input rises (two register stages).
- R3: A feedback rising edge clears a high `up`, so `up` stays high for exactly as many clocks as the feedback edge lags the reference edge. In the same way, when both outputs are low, a feedback edge raises `dn`.
- R4: A reference edge that arrives while `dn` is high clears `dn` and does not raise `up`, so `dn` stays high for exactly the lead of the feedback edge.
- R5: Rising edges on both inputs in the same sample clear both outputs and set neither, so edges that coincide give no pulse.
- R6: `up` and `dn` are never high in the same cycle.
- R7: `acc` is two's complement. It rises by STEP on each clock that `up` is high, falls by STEP on each clock that `dn` is high, and holds otherwise. The new value appears one clock after the pump output.
- R8: `acc` saturates. It clamps at +(2^(ACC_W-1))-1 and at -(2^(ACC_W-1)) and never wraps.
- R9: When the reference runs faster than the feedback, only `up` pulses and `dn` stays low. When the feedback runs faster, only `dn` pulses.
- R10: At each reference rising edge, the reference period that just ended counts as good if no pulse in it was wider than `lock_width` clocks. A pulse of exactly `lock_width` clocks still counts as good.
- R11: `locked` goes high once `lock_periods` good periods have occurred in a row. A bad period resets the run and clears `locked`. `locked` changes only at reference edges, in the same cycle that a pump output responding to that edge would change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference input, edges compared |
| fb_in | input | 1 | Feedback input, edges compared |
| lock_width | input | TW | Widest pulse, in clocks, still counted as good |
| lock_periods | input | LCW | Consecutive good reference periods needed for lock |
| up | output | 1 | Pump-up pulse, reference leads |
| dn | output | 1 | Pump-down pulse, feedback leads |
| acc | output | ACC_W | Signed saturating integrator value |
| locked | output | 1 | Lock indication |

## Verification
A pump output responds two clock edges after the input rise that caused it. The accumulator follows one edge after that, and `locked` moves on the same edge as the pump output. The bench checks exact latency only in one directed case, sampling on falling edges at the precise cycle. Everywhere else it counts pulse cycles over a whole edge-pair window, and every window ends with an idle tail longer than the three-stage pipeline. The accumulator difference and the lock flag are read only after that tail, so no result depends on where exactly a pulse lands.

// File: rtl/pfd_types_pkg.sv
package pfd_types_pkg;

    // Pump output pair driven by the edge state machine
    typedef struct packed {
        logic up;
        logic dn;
    } pump_t;

endpackage

// File: rtl/rise_detect.sv
module rise_detect (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise
);
    typedef struct packed {
        logic now;
        logic prev;
    } smp_t;

    smp_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.now  = sig;
        s_d.prev = s_q.now;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign rise = s_q.now & ~s_q.prev;
endmodule

// File: rtl/pump_fsm.sv
module pump_fsm
    import pfd_types_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ref_rise,
    input  logic  fb_rise,
    output pump_t pump
);
    pump_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (ref_rise && fb_rise) begin
            // coincident edges: zero phase error, nothing to pump
            p_d = '0;
        end else if (ref_rise) begin
            if (p_q.dn) p_d.dn = 1'b0;
            else        p_d.up = 1'b1;
        end else if (fb_rise) begin
            if (p_q.up) p_d.up = 1'b0;
            else        p_d.dn = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end

    assign pump = p_q;
endmodule

// File: rtl/charge_accum.sv
module charge_accum #(
    parameter int ACC_W = 16,
    parameter int STEP  = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    up,
    input  logic                    dn,
    output logic signed [ACC_W-1:0] acc
);
    localparam int XW   = ACC_W + 2;
    localparam int HI_I = (1 << (ACC_W - 1)) - 1;
    localparam int LO_I = -(1 << (ACC_W - 1));
    localparam logic signed [XW-1:0] HI_X   = XW'(HI_I);
    localparam logic signed [XW-1:0] LO_X   = XW'(LO_I);
    localparam logic signed [XW-1:0] STEP_X = XW'(STEP);

    typedef struct packed {
        logic signed [ACC_W-1:0] val;
    } acc_t;

    acc_t a_d, a_q;
    logic signed [XW-1:0] wide, sum;

    always_comb begin
        a_d  = a_q;
        wide = {{2{a_q.val[ACC_W-1]}}, a_q.val};
        sum  = wide;
        if (up && !dn)      sum = wide + STEP_X;
        else if (dn && !up) sum = wide - STEP_X;
        if (sum > HI_X)      a_d.val = HI_X[ACC_W-1:0];
        else if (sum < LO_X) a_d.val = LO_X[ACC_W-1:0];
        else                 a_d.val = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) a_q <= '0;
        else     a_q <= a_d;
    end

    assign acc = a_q.val;
endmodule

// File: rtl/lock_watch.sv
module lock_watch #(
    parameter int TW  = 6,
    parameter int LCW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ref_rise,
    input  logic           up,
    input  logic           dn,
    input  logic [TW-1:0]  lock_width,
    input  logic [LCW-1:0] lock_periods,
    output logic           locked
);
    typedef struct packed {
        logic [TW-1:0]  wid;
        logic           bad;
        logic [LCW-1:0] good;
        logic           locked;
    } lk_t;

    lk_t l_d, l_q;
    logic active, excess, closing_bad;

    always_comb begin
        l_d         = l_q;
        active      = up | dn;
        excess      = active && (l_q.wid >= lock_width);
        closing_bad = l_q.bad | excess;

        if (!active)             l_d.wid = '0;
        else if (&l_q.wid)       l_d.wid = l_q.wid;
        else                     l_d.wid = l_q.wid + 1'b1;

        if (ref_rise) begin
            l_d.bad = 1'b0;
            if (closing_bad)     l_d.good = '0;
            else if (&l_q.good)  l_d.good = l_q.good;
            else                 l_d.good = l_q.good + 1'b1;
            l_d.locked = (l_d.good >= lock_periods);
        end else begin
            l_d.bad = closing_bad;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) l_q <= '0;
        else     l_q <= l_d;
    end

    assign locked = l_q.locked;
endmodule

// File: rtl/pfd_integrator.sv
module pfd_integrator #(
    parameter int ACC_W = 16,
    parameter int STEP  = 1,
    parameter int TW    = 6,
    parameter int LCW   = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ref_in,
    input  logic                    fb_in,
    input  logic [TW-1:0]           lock_width,
    input  logic [LCW-1:0]          lock_periods,
    output logic                    up,
    output logic                    dn,
    output logic signed [ACC_W-1:0] acc,
    output logic                    locked
);
    import pfd_types_pkg::*;

    localparam int NIN = 2;

    logic [NIN-1:0] raw, rises;
    pump_t          pump;

    assign raw = {fb_in, ref_in};

    for (genvar i = 0; i < NIN; i++) begin : g_sense
        rise_detect u_rd (
            .clk  (clk),
            .rst  (rst),
            .sig  (raw[i]),
            .rise (rises[i])
        );
    end

    pump_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ref_rise (rises[0]),
        .fb_rise  (rises[1]),
        .pump     (pump)
    );

    charge_accum #(.ACC_W(ACC_W), .STEP(STEP)) u_acc (
        .clk (clk),
        .rst (rst),
        .up  (pump.up),
        .dn  (pump.dn),
        .acc (acc)
    );

    lock_watch #(.TW(TW), .LCW(LCW)) u_lock (
        .clk          (clk),
        .rst          (rst),
        .ref_rise     (rises[0]),
        .up           (pump.up),
        .dn           (pump.dn),
        .lock_width   (lock_width),
        .lock_periods (lock_periods),
        .locked       (locked)
    );

    assign up = pump.up;
    assign dn = pump.dn;
endmodule

// File: rtl/pfd_integrator_chk.sv
module pfd_integrator_chk #(
    parameter int ACC_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    up,
    input logic                    dn,
    input logic signed [ACC_W-1:0] acc
);
    localparam logic signed [ACC_W-1:0] HI = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] LO = {1'b1, {(ACC_W-1){1'b0}}};

    // R6
    pump_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({up, dn}));

    // R7
    acc_rise_chk: assert property (@(posedge clk) disable iff (rst)
        up |=> acc >= $past(acc));

    // R7
    acc_fall_chk: assert property (@(posedge clk) disable iff (rst)
        dn |=> acc <= $past(acc));

    // R7
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!up && !dn) |=> $stable(acc));

    // R8
    acc_top_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (up && acc == HI) |=> acc == HI);

    // R8
    acc_bottom_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (dn && acc == LO) |=> acc == LO);
endmodule

bind pfd_integrator pfd_integrator_chk #(.ACC_W(ACC_W)) u_chk (
    .clk (clk),
    .rst (rst),
    .up  (up),
    .dn  (dn),
    .acc (acc)
);

// File: tb/sim_pfd_integrator.sv
module sim_pfd_integrator;
    localparam int ACC_W = 8;
    localparam int STEP  = 3;
    localparam int TW    = 6;
    localparam int LCW   = 4;
    localparam int NVEC  = 6;
    // each row: edge separation (fb rise minus ref rise), up width, dn width, acc change
    localparam int VEC [NVEC][4] = '{
        '{ 4, 4, 0,  12},
        '{-2, 0, 2,  -6},
        '{ 0, 0, 0,   0},
        '{ 1, 1, 0,   3},
        '{-5, 0, 5, -15},
        '{ 7, 7, 0,  21}
    };

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    ref_in = 1'b0;
    logic                    fb_in = 1'b0;
    logic [TW-1:0]           lock_width = '0;
    logic [LCW-1:0]          lock_periods = '0;
    logic                    up, dn, locked;
    logic signed [ACC_W-1:0] acc;

    int n_checks = 0;
    int n_fail   = 0;
    int upw, dnw;
    bit finished = 0;

    always #2 clk = ~clk;

    pfd_integrator #(.ACC_W(ACC_W), .STEP(STEP), .TW(TW), .LCW(LCW)) u0 (
        .clk (clk), .rst (rst), .ref_in (ref_in), .fb_in (fb_in),
        .lock_width (lock_width), .lock_periods (lock_periods),
        .up (up), .dn (dn), .acc (acc), .locked (locked)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // one reference rise and one feedback rise, d = fb delay relative to ref
    task automatic edge_pair(input int d);
        int a, b, span;
        a = (d < 0) ? -d : 0;
        b = (d > 0) ?  d : 0;
        span = ((a > b) ? a : b) + 3;
        upw = 0; dnw = 0;
        for (int c = 0; c < span; c++) begin
            ref_in = (c >= a);
            fb_in  = (c >= b);
            @(negedge clk);
            upw += int'(up); dnw += int'(dn);
        end
        ref_in = 1'b0; fb_in = 1'b0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            upw += int'(up); dnw += int'(dn);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int acc0;
        do_reset();
        @(negedge clk);
        // R1 reset state
        check("R1 up", int'(up), 0);
        check("R1 dn", int'(dn), 0);
        check("R1 acc", int'(acc), 0);
        check("R1 locked", int'(locked), 0);

        // R2 latency of up
        ref_in = 1'b1;
        @(negedge clk);
        check("R2 up one edge after rise", int'(up), 0);
        @(negedge clk);
        check("R2 up two edges after rise", int'(up), 1);
        fb_in = 1'b1;
        repeat (4) @(negedge clk);
        ref_in = 1'b0; fb_in = 1'b0;
        repeat (4) @(negedge clk);

        // vector table: R3 / R4 / R5 widths, R7 accumulator change
        do_reset();
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            tag = (VEC[v][0] > 0) ? "R3" : ((VEC[v][0] < 0) ? "R4" : "R5");
            acc0 = int'(acc);
            edge_pair(VEC[v][0]);
            check({tag, " up width"}, upw, VEC[v][1]);
            check({tag, " dn width"}, dnw, VEC[v][2]);
            check("R7 acc change", int'(acc) - acc0, VEC[v][3]);
        end

        // R9 reference twice as fast as feedback
        do_reset();
        upw = 0; dnw = 0;
        for (int c = 0; c < 64; c++) begin
            ref_in = ((c % 8) < 4);
            fb_in  = (((c + 13) % 16) < 8);
            @(negedge clk);
            upw += int'(up); dnw += int'(dn);
        end
        check("R9 fast ref dn silent", dnw, 0);
        check("R9 fast ref up active", int'(upw > 0), 1);

        // R9 feedback twice as fast as reference
        do_reset();
        upw = 0; dnw = 0;
        for (int c = 0; c < 64; c++) begin
            fb_in  = ((c % 8) < 4);
            ref_in = (((c + 13) % 16) < 8);
            @(negedge clk);
            upw += int'(up); dnw += int'(dn);
        end
        check("R9 fast fb up silent", upw, 0);
        check("R9 fast fb dn active", int'(dnw > 0), 1);

        // R8 upper clamp
        do_reset();
        ref_in = 1'b1;
        repeat (60) @(negedge clk);
        check("R8 acc at max", int'(acc), 127);
        repeat (5) @(negedge clk);
        check("R8 acc held at max", int'(acc), 127);
        check("R8 up still high", int'(up), 1);
        fb_in = 1'b1;
        repeat (4) @(negedge clk);
        fb_in = 1'b0;
        repeat (2) @(negedge clk);
        fb_in = 1'b1;
        repeat (120) @(negedge clk);
        check("R8 acc at min", int'(acc), -128);

        // R1 reset in mid-run with dn high
        rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0;
        @(negedge clk);
        check("R1 mid dn", int'(dn), 0);
        check("R1 mid acc", int'(acc), 0);
        check("R1 mid up", int'(up), 0);
        check("R1 mid locked", int'(locked), 0);
        rst = 1'b0;

        // R10 / R11 lock monitor: width limit 2, three periods
        lock_width = TW'(2); lock_periods = LCW'(3);
        do_reset();
        edge_pair(2);
        edge_pair(2);
        check("R11 two good periods not locked", int'(locked), 0);
        edge_pair(2);
        check("R10 width equal to limit counts good, locked", int'(locked), 1);
        edge_pair(3);
        check("R11 lock kept while wide period still open", int'(locked), 1);
        edge_pair(1);
        check("R10 wide pulse drops lock", int'(locked), 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule